// File: doc/BRIEF.md
# Control-Flow Instruction Execution Unit

This unit carries out the jump class of a small 16-bit processor. One instruction format covers several operations. An absolute or relative jump takes its target from a general register. A call also pushes the return address onto a memory stack. A return takes its target from the top of that stack. A software trap sends the program counter to address zero. Any of these may also rewrite the interrupt-enable flag. The unit decodes the flag bits of the first instruction word and a source register index from the second. It reads the register file through a combinational read port and talks to a synchronous, word-addressed stack memory with a one-cycle read latency.

The surrounding core owns the program counter and the stack pointer. It presents their current values on `pcIn` and `spIn` and commits the write strobes the unit raises in its completion cycle. The interrupt-enable flag lives inside the unit and is visible on `intEn`.

A start is accepted only while the unit is idle. Most instructions complete in the cycle after the start. An instruction that pops the stack needs one more cycle to wait for the memory read. Every accepted instruction ends with exactly one `done` pulse.

Top module: `cfu_top`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `pcWe`, `spWe`, `memRe` and `memWe` are 0, and `intEn` is 0.
- R2: The opcode field is `instr0[15:8]`, and only the value 0x04 belongs to this unit. For any other value, `done` and `err` are both 1 in the cycle after the start. In that case no program counter, stack pointer or memory write occurs, and `intEn` keeps its value.
- R3: The flag bits of `instr0` are: bit 7 relative, bit 6 push, bit 5 pop, bit 4 trap, bit 3 interrupt-enable write, bit 2 interrupt-enable value. When pop is clear, `rfRdIdx` equals `instr1[15:11]`. The target is `rfRdData`, and `done` and `pcWe` rise in the cycle after the start.
- R4: With relative clear, `pcNext` equals the target. With relative set, `pcNext` equals `pcIn` plus the target, modulo 2^16.
- R5: With push set, the completion cycle writes `pcIn`+2 to `memAddr`, which is the stack pointer in effect at that point. In the same cycle it raises `spWe` with `spNext` one below that address.
- R6: With pop set, the cycle after the start raises `memRe` at address `spIn`+1 with no other strobe. The next cycle completes, using `memRdata` as the target. Without push, `spNext` is `spIn`+1.
- R7: With both pop and push set, the return address is written to `spIn`+1, which is the slot just vacated, and the final `spNext` equals `spIn`. A read strobe and a write strobe are never high together.
- R8: When trap is set and `intEn` is 1, the instruction completes in the cycle after the start with `pcNext` = 0. It reads no target, so `memRe` stays low even if pop is set. With push set, it stores `pcIn`+2 at `spIn` and sets `spNext` to `spIn`-1.
- R9: When trap is set and `intEn` is 0, the instruction runs as an ordinary jump, call or return as the other flags direct.
- R10: At completion, if the interrupt-enable write bit is 1, `intEn` takes the value bit on the next clock, including on a trap. Otherwise `intEn` keeps its value, and it never changes outside a completion cycle.
- R11: A `start` while `busy` is 1 is ignored. It does not cause a second completion.
- R12: `done` is a single-cycle pulse. `pcWe` is only ever high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction present; accepted when idle |
| instr0 | input | 16 | First instruction word (opcode and flags) |
| instr1 | input | 16 | Second instruction word (source register index) |
| pcIn | input | 16 | Current program counter |
| spIn | input | 16 | Current stack pointer |
| rfRdData | input | 16 | Register file read data for `rfRdIdx` |
| memRdata | input | 16 | Stack memory read data, one cycle after `memRe` |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Opcode not handled, valid with `done` |
| rfRdIdx | output | 5 | Register file read index |
| memRe | output | 1 | Stack memory read strobe |
| memWe | output | 1 | Stack memory write strobe |
| memAddr | output | 16 | Stack memory word address |
| memWdata | output | 16 | Stack memory write data |
| pcWe | output | 1 | Program counter write strobe |
| pcNext | output | 16 | New program counter |
| spWe | output | 1 | Stack pointer write strobe |
| spNext | output | 16 | New stack pointer |
| intEn | output | 1 | Interrupt-enable flag |

## Verification
On every cycle the assertions check the following. The completion pulse is single and error completions write nothing. A read and a write never happen together. A pop read is always followed by a completion. A trap never reads. Every push lowers the stack pointer below the written slot. The interrupt-enable flag changes only at completion. The bench scenarios are needed to show the actual target values. These include the wrapping relative sum, the pop-then-push slot reuse, the choice between trap and jump as a function of the enable flag, and the fact that a start held during execution is dropped.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  localparam int OPC_LSB = 8;
  localparam int OPC_W   = 8;
  localparam logic [OPC_W-1:0] OPC_FLOW = 8'h04;

  // flag positions inside the first word
  localparam int BIT_REL   = 7;
  localparam int BIT_PUSH  = 6;
  localparam int BIT_POP   = 5;
  localparam int BIT_TRAP  = 4;
  localparam int BIT_IEWR  = 3;
  localparam int BIT_IEVAL = 2;

  typedef struct packed {
    logic rel;
    logic push;
    logic pop;
    logic trap;
    logic ieWr;
    logic ieVal;
  } flags_t;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;
    logic popIssue;
    logic finReg;
    logic finPop;
    logic trapGo;
    logic badOp;
  } strobe_t;

  // datapath -> control decode
  typedef struct packed {
    logic opOk;
    logic popSel;
    logic trapReq;
  } decode_t;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_POPW} state_t;
endpackage

// File: rtl/cfu_ctrl.sv
module cfu_ctrl
  import cfu_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  decode_t dec,
  output strobe_t strb,
  output logic    busy,
  output logic    done,
  output logic    err
);
  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.capture = 1'b1;
          stateNext = ST_EXEC;
        end
      end
      ST_EXEC: begin
        stateNext = ST_IDLE;
        if (!dec.opOk)        strb.badOp = 1'b1;
        else if (dec.trapReq) strb.trapGo = 1'b1;
        else if (dec.popSel) begin
          strb.popIssue = 1'b1;
          stateNext = ST_POPW;
        end
        else                  strb.finReg = 1'b1;
      end
      ST_POPW: begin
        strb.finPop = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = strb.badOp | strb.trapGo | strb.finReg | strb.finPop;
  assign err  = strb.badOp;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R12
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN) err |-> done); // R2
  AST_POP_COMPLETES: assert property (@(posedge clk) disable iff (!rstN) strb.popIssue |=> strb.finPop); // R6
  AST_BUSY_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rstN) busy |-> !strb.capture); // R11
endmodule

// File: rtl/cfu_datapath.sv
module cfu_datapath
  import cfu_pkg::*;
#(
  parameter int DataW = 16,
  parameter int IdxW  = 5,
  parameter int Step  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DataW-1:0] instr0,
  input  logic [DataW-1:0] instr1,
  input  logic [DataW-1:0] pcIn,
  input  logic [DataW-1:0] spIn,
  input  logic [DataW-1:0] rfRdData,
  input  logic [DataW-1:0] memRdata,
  input  strobe_t          strb,
  output decode_t          dec,
  output logic [IdxW-1:0]  rfRdIdx,
  output logic             memRe,
  output logic             memWe,
  output logic [DataW-1:0] memAddr,
  output logic [DataW-1:0] memWdata,
  output logic             pcWe,
  output logic [DataW-1:0] pcNext,
  output logic             spWe,
  output logic [DataW-1:0] spNext,
  output logic             intEn
);
  localparam int IdxLsb = DataW - IdxW;
  localparam logic [DataW-1:0] StepW = DataW'(Step);
  localparam logic [DataW-1:0] One   = DataW'(1);

  logic [OPC_W-1:0] opcR;
  flags_t           flgR;
  logic [IdxW-1:0]  idxR;
  logic [DataW-1:0] pcR, spR;
  logic             ieR;
  flags_t           flgIn;
  logic [DataW-1:0] target, jumpDest, retAddr;
  logic             finish, commit;

  // bits of the words that carry no meaning for this class
  logic unusedBits;
  assign unusedBits = ^{instr0[1:0], instr1[IdxLsb-1:0]};

  assign flgIn = '{rel:   instr0[BIT_REL],   push: instr0[BIT_PUSH],
                   pop:   instr0[BIT_POP],   trap: instr0[BIT_TRAP],
                   ieWr:  instr0[BIT_IEWR],  ieVal: instr0[BIT_IEVAL]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcR <= '0;
      flgR <= '0;
      idxR <= '0;
      pcR  <= '0;
      spR  <= '0;
      ieR  <= 1'b0;
    end else begin
      if (strb.capture) begin
        opcR <= instr0[OPC_LSB +: OPC_W];
        flgR <= flgIn;
        idxR <= instr1[IdxLsb +: IdxW];
        pcR  <= pcIn;
        spR  <= spIn;
      end
      if (strb.popIssue) spR <= spR + One;   // pre-increment before the read
      if (commit && flgR.ieWr) ieR <= flgR.ieVal;
    end
  end

  assign dec.opOk    = (opcR == OPC_FLOW);
  assign dec.popSel  = flgR.pop;
  assign dec.trapReq = flgR.trap & ieR;

  assign finish   = strb.finReg | strb.finPop;
  assign commit   = finish | strb.trapGo;
  assign target   = strb.finPop ? memRdata : rfRdData;
  assign jumpDest = flgR.rel ? (pcR + target) : target;
  assign retAddr  = pcR + StepW;

  assign rfRdIdx  = idxR;
  assign memRe    = strb.popIssue;
  assign memWe    = commit & flgR.push;
  assign memAddr  = strb.popIssue ? (spR + One) : spR;
  assign memWdata = retAddr;
  assign pcWe     = commit;
  assign pcNext   = strb.trapGo ? '0 : jumpDest;
  assign spWe     = (finish & (flgR.push | flgR.pop)) | (strb.trapGo & flgR.push);
  assign spNext   = flgR.push ? (spR - One) : spR;
  assign intEn    = ieR;

  AST_ONE_MEM_OP: assert property (@(posedge clk) disable iff (!rstN) !(memRe && memWe)); // R7
  AST_TRAP_NO_READ: assert property (@(posedge clk) disable iff (!rstN) strb.trapGo |-> !memRe); // R8
  AST_PUSH_LOWERS_SP: assert property (@(posedge clk) disable iff (!rstN) memWe |-> (spWe && spNext == memAddr - One)); // R5
  AST_IE_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rstN) !commit |=> $stable(intEn)); // R10
endmodule

// File: rtl/cfu_top.sv
module cfu_top
  import cfu_pkg::*;
#(
  parameter int DataW = 16,
  parameter int IdxW  = 5,
  parameter int Step  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DataW-1:0] instr0,
  input  logic [DataW-1:0] instr1,
  input  logic [DataW-1:0] pcIn,
  input  logic [DataW-1:0] spIn,
  input  logic [DataW-1:0] rfRdData,
  input  logic [DataW-1:0] memRdata,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [IdxW-1:0]  rfRdIdx,
  output logic             memRe,
  output logic             memWe,
  output logic [DataW-1:0] memAddr,
  output logic [DataW-1:0] memWdata,
  output logic             pcWe,
  output logic [DataW-1:0] pcNext,
  output logic             spWe,
  output logic [DataW-1:0] spNext,
  output logic             intEn
);
  strobe_t strb;
  decode_t dec;

  cfu_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .dec(dec), .strb(strb),
    .busy(busy), .done(done), .err(err)
  );

  cfu_datapath #(.DataW(DataW), .IdxW(IdxW), .Step(Step)) uPath (
    .clk(clk), .rstN(rstN), .instr0(instr0), .instr1(instr1),
    .pcIn(pcIn), .spIn(spIn), .rfRdData(rfRdData), .memRdata(memRdata),
    .strb(strb), .dec(dec), .rfRdIdx(rfRdIdx), .memRe(memRe), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .pcWe(pcWe), .pcNext(pcNext),
    .spWe(spWe), .spNext(spNext), .intEn(intEn)
  );

  AST_PCWE_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN) pcWe |-> done); // R12
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN) err |-> (!pcWe && !spWe && !memWe)); // R2
endmodule

// File: tb/tb_cfu_top.sv
`timescale 1ns/1ps
module tb_cfu_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr0 = '0, instr1 = '0;
  logic [15:0] pcReg = '0, spReg = '0;
  logic [15:0] rfRdData, memRdata = '0;
  logic        busy, done, err, memRe, memWe, pcWe, spWe, intEn;
  logic [4:0]  rfRdIdx;
  logic [15:0] memAddr, memWdata, pcNext, spNext;

  logic [15:0] regs [0:31];
  logic [15:0] mem  [0:255];
  int checks = 0, errors = 0;
  bit mIe = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  cfu_top dut (
    .clk(clk), .rstN(rstN), .start(start), .instr0(instr0), .instr1(instr1),
    .pcIn(pcReg), .spIn(spReg), .rfRdData(rfRdData), .memRdata(memRdata),
    .busy(busy), .done(done), .err(err), .rfRdIdx(rfRdIdx), .memRe(memRe),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .pcWe(pcWe),
    .pcNext(pcNext), .spWe(spWe), .spNext(spNext), .intEn(intEn)
  );

  // harness: register file, stack memory, pc/sp storage
  assign rfRdData = regs[rfRdIdx];
  always @(posedge clk) begin
    if (memRe) memRdata <= mem[memAddr[7:0]];
    if (memWe) mem[memAddr[7:0]] <= memWdata;
    if (pcWe)  pcReg <= pcNext;
    if (spWe)  spReg <= spNext;
  end

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chkCyc(input string req, input bit eDone, input bit eErr, input bit ePcWe,
                        input logic [15:0] ePc, input bit eSpWe, input logic [15:0] eSp,
                        input bit eRe, input bit eWe, input logic [15:0] eAddr, input logic [15:0] eData);
    chk(req, "done", 16'(done), 16'(eDone));
    chk(req, "err", 16'(err), 16'(eErr));
    chk(req, "pcWe", 16'(pcWe), 16'(ePcWe));
    if (ePcWe) chk(req, "pcNext", pcNext, ePc);
    chk(req, "spWe", 16'(spWe), 16'(eSpWe));
    if (eSpWe) chk(req, "spNext", spNext, eSp);
    chk(req, "memRe", 16'(memRe), 16'(eRe));
    chk(req, "memWe", 16'(memWe), 16'(eWe));
    if (eRe || eWe) chk(req, "memAddr", memAddr, eAddr);
    if (eWe) chk(req, "memWdata", memWdata, eData);
  endtask

  function automatic logic [15:0] enc(bit j, bit s, bit p, bit i, bit t, bit t2);
    return 16'h0400 | (16'(j) << 7) | (16'(s) << 6) | (16'(p) << 5) | (16'(i) << 4) | (16'(t) << 3) | (16'(t2) << 2);
  endfunction

  // one instruction, checked cycle by cycle against a behavioural model
  task automatic runInstr(input string req, input logic [15:0] w0, input logic [15:0] w1, input bit hold);
    bit j = w0[7], s = w0[6], p = w0[5], i = w0[4], t = w0[3], t2 = w0[2];
    bit opOk = (w0[15:8] == 8'h04);
    logic [15:0] p0 = pcReg, s0 = spReg, tgt, dest, fPc = pcReg, fSp = spReg;
    @(negedge clk);
    start = 1'b1; instr0 = w0; instr1 = w1;
    @(negedge clk);
    if (hold) instr0 = 16'h0900;          // bad opcode offered while busy
    else start = 1'b0;
    chk(req, "busy", 16'(busy), 16'd1);
    if (!opOk) begin
      chkCyc(req, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    end else if (i && mIe) begin
      fPc = 16'h0000;
      if (s) fSp = s0 - 16'd1;
      chkCyc(req, 1, 0, 1, 16'h0000, s, s0 - 16'd1, 0, s, s0, p0 + 16'd2);
      if (t) mIe = t2;
    end else if (p) begin
      chkCyc(req, 0, 0, 0, 0, 0, 0, 1, 0, s0 + 16'd1, 0);
      tgt = mem[8'(s0 + 16'd1)];
      dest = j ? p0 + tgt : tgt;
      fPc = dest;
      fSp = s ? s0 : s0 + 16'd1;
      @(negedge clk);
      start = 1'b0;
      chkCyc(req, 1, 0, 1, dest, 1, fSp, 0, s, s0 + 16'd1, p0 + 16'd2);
      if (t) mIe = t2;
    end else begin
      chk(req, "rfRdIdx", 16'(rfRdIdx), 16'(w1[15:11]));
      tgt = regs[w1[15:11]];
      dest = j ? p0 + tgt : tgt;
      fPc = dest;
      if (s) fSp = s0 - 16'd1;
      chkCyc(req, 1, 0, 1, dest, s, s0 - 16'd1, 0, s, s0, p0 + 16'd2);
      if (t) mIe = t2;
    end
    @(negedge clk);
    start = 1'b0;
    chkCyc(req, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);   // idle again, nothing pending
    chk(req, "busy after", 16'(busy), 16'd0);
    chk(req, "intEn", 16'(intEn), 16'(mIe));
    chk(req, "final pc", pcReg, fPc);
    chk(req, "final sp", spReg, fSp);
  endtask

  initial begin
    for (int k = 0; k < 32; k++) regs[k] = 16'(16'h1000 + k * 16'h0111);
    for (int k = 0; k < 256; k++) mem[k] = 16'(16'hA000 + k);
    regs[5] = 16'h1234; regs[7] = 16'h0020; regs[3] = 16'h0400; regs[9] = 16'h00F0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chkCyc("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1", "busy", 16'(busy), 16'd0);
    chk("R1", "intEn", 16'(intEn), 16'd0);
    rstN = 1'b1;
    pcReg = 16'h0100; spReg = 16'h0080;

    runInstr("R2", 16'h0580, 16'h2800, 0);                    // wrong opcode
    runInstr("R3", enc(0,0,0,0,0,0), 16'(5) << 11, 0);        // absolute via r5
    pcReg = 16'hFFF0;
    runInstr("R4", enc(1,0,0,0,0,0), 16'(7) << 11, 0);        // relative, wraps
    runInstr("R5", enc(0,1,0,0,0,0), 16'(3) << 11, 0);        // call r3
    runInstr("R10", enc(0,0,0,0,1,1), 16'(9) << 11, 0);       // jump, enable set
    runInstr("R6", enc(0,0,1,0,0,0), 16'h0000, 0);            // return
    runInstr("R7", enc(0,1,1,0,0,0), 16'h0000, 0);            // pop then push
    runInstr("R8", enc(0,1,1,1,1,0), 16'h0000, 0);            // trap, clears enable
    runInstr("R9", enc(0,0,0,1,0,0), 16'(5) << 11, 0);        // trap disabled
    runInstr("R4", enc(1,0,1,0,0,0), 16'h0000, 0);            // relative pop
    runInstr("R11", enc(0,0,0,0,0,0), 16'(3) << 11, 1);       // start held while busy
    runInstr("R10", enc(0,0,0,0,0,1), 16'(7) << 11, 0);       // no write bit: unchanged
    runInstr("R10", enc(0,0,0,0,1,1), 16'(5) << 11, 0);
    runInstr("R8", enc(0,0,0,1,0,0), 16'(7) << 11, 0);        // trap, no push
    runInstr("R12", enc(1,1,0,1,0,0), 16'(9) << 11, 0);       // trap with push
    runInstr("R2", 16'h0300, 16'h0000, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule